// File: doc/BRIEF.md
# CPU exception entry controller

This block is the entry stage for exceptions and interrupts in a 32-bit RISC core. Each cycle it takes one-cycle request pulses for the two resets, the MMU multiple-hit faults and a vector of synchronous faults. It also takes a non-maskable interrupt and a 4-bit external interrupt level. It picks one winner by fixed priority and computes the register updates that entering the handler implies: the new PC, the saved PC, status and R15, the event code, the trap code, the faulting address and the new status word.

The core presents its current PC, status register, R15, VBR, delay-slot flag, trap immediate and faulting address together with the requests. The results appear on registered outputs one clock later, with a one-cycle `taken` strobe that tells the pipeline to flush and load the outputs into its architectural registers. Outputs not touched by an entry keep their previous value.

The status word uses these fields: MD bit 30, RB bit 29, BL bit 28, FD bit 15, interrupt mask bits 7:4.

Top module: `excEntry`

## Requirements
- R1: After reset every output is zero, including `taken` and `newSlot`.
- R2: `rstReq[0]` (power-on) writes event code 0x000 and `rstReq[1]` (manual) writes 0x020; power-on wins when both are set. Either one sets `newPc` to 0xA0000000 and `newVbr` to 0. `newSr` is the current status with MD, RB and BL set, mask 0xF and FD cleared. The saved PC, status and R15 are left unchanged.
- R3: Any bit of `mhitReq` (instruction or operand TLB multiple hit) is treated like a reset with event code 0x140, and it latches `faultAddr` into `tea`.
- R4: Fault bits 0 and 9 (instruction and read TLB miss) write code 0x040 and fault bit 10 (write TLB miss) writes 0x060. All three vector to VBR+0x400.
- R5: The other fault bits vector to VBR+0x100 with these codes: 1→0x0E0, 2→0x0A0, 3→0x180, 4→0x1A0, 5→0x800, 6→0x820, 7→0x160 (trap), 8→0x1E0 (break before), 11→0x080, 12→0x0A0, 13→0x0C0, 14→0x0E0, 15→0x100, 16→0x120, 17→0x1E0 (break after).
- R6: Every non-reset entry copies the current PC (adjusted per R7), status and R15 to `savedPc`, `savedSr` and `savedR15`. `newSr` is the current status with MD, RB and BL set and the mask and FD unchanged. `newVbr` takes the current VBR.
- R7: The trap (bit 7) and the break after (bit 17) save PC+2. The illegal slot (bit 4) and the slot FPU disabled (bit 6) save PC-2. All other causes save PC.
- R8: A trap sets `tra` to the 8-bit immediate shifted left by two. No other cause changes `tra`.
- R9: NMI writes interrupt code 0x1C0 and an accepted level L writes 0x200 + (15-L)*0x20. Both vector to VBR+0x600, write `intEvt` and leave `expEvt` unchanged.
- R10: A level interrupt is accepted only when BL is 0 and L is above the mask; level 0 means no request. NMI is accepted regardless of BL.
- R11: The priority, highest first, is power-on, manual, multiple hit, the lowest-numbered fault bit, NMI, level interrupt.
- R12: `tea` takes `faultAddr` for fault bits 0, 1, 2 and 9 through 15 and for multiple hits. It is unchanged for every other cause.
- R13: All outputs update at the first clock after the request. `taken` is high for exactly the cycles that follow an accepted request. `newSlot` is 0 after an entry and otherwise follows `inDelaySlot` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rstReq | input | 2 | Bit 0 power-on, bit 1 manual reset request |
| mhitReq | input | 2 | Instruction / operand TLB multiple-hit request |
| faultReq | input | 18 | Synchronous fault requests, bit index per R4/R5 |
| nmiReq | input | 1 | Non-maskable interrupt |
| irqLevel | input | 4 | External interrupt level, 0 = none |
| curPc | input | 32 | PC of the faulting instruction |
| curSr | input | 32 | Current status register |
| curR15 | input | 32 | Current R15 |
| curVbr | input | 32 | Current vector base |
| inDelaySlot | input | 1 | Current delay-slot flag |
| trapImm | input | 8 | Trap immediate |
| faultAddr | input | 32 | Faulting address |
| taken | output | 1 | Entry taken, flush strobe |
| newPc | output | 32 | Handler address |
| newVbr | output | 32 | VBR after entry |
| newSr | output | 32 | Status after entry |
| savedPc | output | 32 | Saved PC |
| savedSr | output | 32 | Saved status |
| savedR15 | output | 32 | Saved R15 |
| expEvt | output | 32 | Exception event code |
| intEvt | output | 32 | Interrupt event code |
| tra | output | 32 | Trap code |
| tea | output | 32 | Faulting address |
| newSlot | output | 1 | Delay-slot flag after the cycle |

## Verification
The bench walks every fault bit alone and checks its code, vector and PC offset. A table typo or a missing offset shows up as a wrong `expEvt` or a `savedPc` that is off by two. Requests are stacked in pairs to expose a reversed priority, for example a load fault that wins over an older fetch fault, or an NMI that wins over a synchronous fault. Interrupt levels equal to the mask and interrupts raised with BL set must produce no `taken`; an off-by-one compare would enter the handler there. Reset-class entries must leave the saved context and `tra` alone, and non-MMU causes must leave `tea` holding its previous address.

// File: rtl/excPkg.sv
package excPkg;

  localparam int XLEN      = 32;
  localparam int NUM_FAULT = 18;
  localparam int IDX_W     = $clog2(NUM_FAULT);
  localparam int CODE_W    = 12;
  localparam int LVL_W     = 4;

  localparam logic [XLEN-1:0] RESET_VEC = 32'hA000_0000;
  localparam logic [XLEN-1:0] OFS_GEN   = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_TLB   = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFS_INT   = 32'h0000_0600;

  localparam int SR_MD = 30;
  localparam int SR_RB = 29;
  localparam int SR_BL = 28;
  localparam int SR_FD = 15;
  localparam int SR_IM = 4;

  typedef enum logic [1:0] {CLS_NONE, CLS_RESET, CLS_GEN, CLS_INT} entryClass_e;
  typedef enum logic [1:0] {VEC_RESET, VEC_GEN, VEC_TLB, VEC_INT} vecSel_e;
  typedef enum logic [1:0] {ADJ_NONE, ADJ_PLUS2, ADJ_MINUS2} pcAdj_e;

  typedef struct packed {
    logic              take;
    entryClass_e       cls;
    vecSel_e           vec;
    pcAdj_e            adj;
    logic              latchTea;
    logic              latchTra;
    logic [CODE_W-1:0] code;
  } ctrlStrobe_t;

  function automatic logic [CODE_W-1:0] faultCode(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd0, 5'd9: faultCode = 12'h040;
      5'd1, 5'd14: faultCode = 12'h0E0;
      5'd2, 5'd12: faultCode = 12'h0A0;
      5'd3:  faultCode = 12'h180;
      5'd4:  faultCode = 12'h1A0;
      5'd5:  faultCode = 12'h800;
      5'd6:  faultCode = 12'h820;
      5'd7:  faultCode = 12'h160;
      5'd8, 5'd17: faultCode = 12'h1E0;
      5'd10: faultCode = 12'h060;
      5'd11: faultCode = 12'h080;
      5'd13: faultCode = 12'h0C0;
      5'd15: faultCode = 12'h100;
      5'd16: faultCode = 12'h120;
      default: faultCode = 12'h000;
    endcase
  endfunction

  function automatic vecSel_e faultVec(input logic [IDX_W-1:0] idx);
    faultVec = (idx == 5'd0 || idx == 5'd9 || idx == 5'd10) ? VEC_TLB : VEC_GEN;
  endfunction

  function automatic pcAdj_e faultAdj(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd7, 5'd17: faultAdj = ADJ_PLUS2;
      5'd4, 5'd6:  faultAdj = ADJ_MINUS2;
      default:     faultAdj = ADJ_NONE;
    endcase
  endfunction

  function automatic logic faultTea(input logic [IDX_W-1:0] idx);
    faultTea = (idx <= 5'd2) || (idx >= 5'd9 && idx <= 5'd15);
  endfunction

endpackage

// File: rtl/excIrqGate.sv
module excIrqGate
  import excPkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic [LW-1:0]     irqLevel,
  input  logic              srBl,
  input  logic [LW-1:0]     srImask,
  output logic              irqAccept,
  output logic [CODE_W-1:0] irqCode
);
  localparam logic [LW-1:0] LVL_MAX = '1;

  logic [LW-1:0] distance;

  always_comb begin
    irqAccept = !srBl && (irqLevel != '0) && (irqLevel > srImask);
    distance  = LVL_MAX - irqLevel;
    irqCode   = 12'h200 + (CODE_W'(distance) << 5);
  end
endmodule

// File: rtl/excControl.sv
module excControl
  import excPkg::*;
#(
  parameter int NF = NUM_FAULT
) (
  input  logic [1:0]        rstReq,
  input  logic [1:0]        mhitReq,
  input  logic [NF-1:0]     faultReq,
  input  logic              nmiReq,
  input  logic              irqAccept,
  input  logic [CODE_W-1:0] irqCode,
  output ctrlStrobe_t       strb
);
  logic [IDX_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (faultReq[i]) sel = IDX_W'(i);
    end
  end

  always_comb begin
    strb.take     = 1'b0;
    strb.cls      = CLS_NONE;
    strb.vec      = VEC_GEN;
    strb.adj      = ADJ_NONE;
    strb.latchTea = 1'b0;
    strb.latchTra = 1'b0;
    strb.code     = '0;
    if (rstReq[0] || rstReq[1]) begin
      strb.take = 1'b1;
      strb.cls  = CLS_RESET;
      strb.vec  = VEC_RESET;
      strb.code = rstReq[0] ? 12'h000 : 12'h020;
    end else if (|mhitReq) begin
      strb.take     = 1'b1;
      strb.cls      = CLS_RESET;
      strb.vec      = VEC_RESET;
      strb.latchTea = 1'b1;
      strb.code     = 12'h140;
    end else if (|faultReq) begin
      strb.take     = 1'b1;
      strb.cls      = CLS_GEN;
      strb.vec      = faultVec(sel);
      strb.adj      = faultAdj(sel);
      strb.latchTea = faultTea(sel);
      strb.latchTra = (sel == 5'd7);
      strb.code     = faultCode(sel);
    end else if (nmiReq) begin
      strb.take = 1'b1;
      strb.cls  = CLS_INT;
      strb.vec  = VEC_INT;
      strb.code = 12'h1C0;
    end else if (irqAccept) begin
      strb.take = 1'b1;
      strb.cls  = CLS_INT;
      strb.vec  = VEC_INT;
      strb.code = irqCode;
    end
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobe_t  strb,
  input  logic [W-1:0] curPc,
  input  logic [W-1:0] curSr,
  input  logic [W-1:0] curR15,
  input  logic [W-1:0] curVbr,
  input  logic         inDelaySlot,
  input  logic [7:0]   trapImm,
  input  logic [W-1:0] faultAddr,
  output logic         taken,
  output logic [W-1:0] newPc,
  output logic [W-1:0] newVbr,
  output logic [W-1:0] newSr,
  output logic [W-1:0] savedPc,
  output logic [W-1:0] savedSr,
  output logic [W-1:0] savedR15,
  output logic [W-1:0] expEvt,
  output logic [W-1:0] intEvt,
  output logic [W-1:0] tra,
  output logic [W-1:0] tea,
  output logic         newSlot
);
  logic [W-1:0] target, pcToSave, srReset, srGen;

  always_comb begin
    case (strb.vec)
      VEC_RESET: target = RESET_VEC;
      VEC_TLB:   target = curVbr + OFS_TLB;
      VEC_INT:   target = curVbr + OFS_INT;
      default:   target = curVbr + OFS_GEN;
    endcase
    case (strb.adj)
      ADJ_PLUS2:  pcToSave = curPc + W'(2);
      ADJ_MINUS2: pcToSave = curPc - W'(2);
      default:    pcToSave = curPc;
    endcase
    srGen = curSr;
    srGen[SR_MD] = 1'b1;
    srGen[SR_RB] = 1'b1;
    srGen[SR_BL] = 1'b1;
    srReset = srGen;
    srReset[SR_FD] = 1'b0;
    srReset[SR_IM +: 4] = 4'hF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taken    <= 1'b0;
      newPc    <= '0;
      newVbr   <= '0;
      newSr    <= '0;
      savedPc  <= '0;
      savedSr  <= '0;
      savedR15 <= '0;
      expEvt   <= '0;
      intEvt   <= '0;
      tra      <= '0;
      tea      <= '0;
      newSlot  <= 1'b0;
    end else begin
      taken   <= strb.take;
      newSlot <= strb.take ? 1'b0 : inDelaySlot;
      if (strb.take) begin
        newPc <= target;
        if (strb.latchTea) tea <= faultAddr;
        if (strb.latchTra) tra <= W'({trapImm, 2'b00});
        if (strb.cls == CLS_RESET) begin
          newVbr <= '0;
          newSr  <= srReset;
          expEvt <= W'(strb.code);
        end else begin
          newVbr   <= curVbr;
          newSr    <= srGen;
          savedPc  <= pcToSave;
          savedSr  <= curSr;
          savedR15 <= curR15;
          if (strb.cls == CLS_INT) intEvt <= W'(strb.code);
          else                     expEvt <= W'(strb.code);
        end
      end
    end
  end
endmodule

// File: rtl/excEntry.sv
module excEntry
  import excPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           rstReq,
  input  logic [1:0]           mhitReq,
  input  logic [NUM_FAULT-1:0] faultReq,
  input  logic                 nmiReq,
  input  logic [LVL_W-1:0]     irqLevel,
  input  logic [XLEN-1:0]      curPc,
  input  logic [XLEN-1:0]      curSr,
  input  logic [XLEN-1:0]      curR15,
  input  logic [XLEN-1:0]      curVbr,
  input  logic                 inDelaySlot,
  input  logic [7:0]           trapImm,
  input  logic [XLEN-1:0]      faultAddr,
  output logic                 taken,
  output logic [XLEN-1:0]      newPc,
  output logic [XLEN-1:0]      newVbr,
  output logic [XLEN-1:0]      newSr,
  output logic [XLEN-1:0]      savedPc,
  output logic [XLEN-1:0]      savedSr,
  output logic [XLEN-1:0]      savedR15,
  output logic [XLEN-1:0]      expEvt,
  output logic [XLEN-1:0]      intEvt,
  output logic [XLEN-1:0]      tra,
  output logic [XLEN-1:0]      tea,
  output logic                 newSlot
);
  logic              irqAccept;
  logic [CODE_W-1:0] irqCode;
  ctrlStrobe_t       strb;

  excIrqGate #(.LW(LVL_W)) i_irqGate (
    .irqLevel (irqLevel),
    .srBl     (curSr[SR_BL]),
    .srImask  (curSr[SR_IM +: LVL_W]),
    .irqAccept(irqAccept),
    .irqCode  (irqCode)
  );

  excControl #(.NF(NUM_FAULT)) i_control (
    .rstReq   (rstReq),
    .mhitReq  (mhitReq),
    .faultReq (faultReq),
    .nmiReq   (nmiReq),
    .irqAccept(irqAccept),
    .irqCode  (irqCode),
    .strb     (strb)
  );

  excDatapath #(.W(XLEN)) i_datapath (
    .clk, .rstN, .strb, .curPc, .curSr, .curR15, .curVbr, .inDelaySlot,
    .trapImm, .faultAddr, .taken, .newPc, .newVbr, .newSr, .savedPc,
    .savedSr, .savedR15, .expEvt, .intEvt, .tra, .tea, .newSlot
  );
endmodule

// File: rtl/excEntryChk.sv
module excEntryChk
  import excPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           rstReq,
  input logic [1:0]           mhitReq,
  input logic [NUM_FAULT-1:0] faultReq,
  input logic                 nmiReq,
  input logic [LVL_W-1:0]     irqLevel,
  input logic [XLEN-1:0]      curSr,
  input logic [XLEN-1:0]      curR15,
  input logic [7:0]           trapImm,
  input logic                 taken,
  input logic [XLEN-1:0]      newPc,
  input logic [XLEN-1:0]      newVbr,
  input logic [XLEN-1:0]      newSr,
  input logic [XLEN-1:0]      savedSr,
  input logic [XLEN-1:0]      savedR15,
  input logic [XLEN-1:0]      tra,
  input logic                 newSlot
);
  logic syncOnly;
  assign syncOnly = (rstReq == '0) && (mhitReq == '0) && (faultReq != '0);

  assert_reset_vector_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq != '0) |=> (taken && newPc == RESET_VEC && newVbr == '0));

  assert_reset_status_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq != '0) |=> (newSr[30:28] == 3'b111 && newSr[7:4] == 4'hF && !newSr[15]));

  assert_context_save_R6: assert property (@(posedge clk) disable iff (!rstN)
    syncOnly |=> (savedSr == $past(curSr) && savedR15 == $past(curR15)
                  && newSr[7:4] == $past(curSr[7:4]) && newSr[30:28] == 3'b111));

  assert_trap_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (syncOnly && faultReq[6:0] == '0 && faultReq[7])
      |=> (tra == {22'd0, $past(trapImm), 2'b00}));

  assert_irq_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((rstReq == '0) && (mhitReq == '0) && (faultReq == '0) && !nmiReq && curSr[28])
      |=> !taken);

  assert_idle_no_take_R13: assert property (@(posedge clk) disable iff (!rstN)
    ((rstReq == '0) && (mhitReq == '0) && (faultReq == '0) && !nmiReq && irqLevel == '0)
      |=> !taken);

  assert_slot_cleared_R13: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> !newSlot);
endmodule

bind excEntry excEntryChk i_chk (.*);

// File: tb/test_excEntry.sv
`timescale 1ns/1ps
module test_excEntry;
  import excPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rstReq = '0, mhitReq = '0;
  logic [NUM_FAULT-1:0] faultReq = '0;
  logic nmiReq = 1'b0;
  logic [3:0] irqLevel = '0;
  logic [31:0] curPc = 32'h8C00_1000, curSr = 32'h0000_8050;
  logic [31:0] curR15 = 32'h8CFF_FFF0, curVbr = 32'h8C00_0000;
  logic inDelaySlot = 1'b0;
  logic [7:0] trapImm = '0;
  logic [31:0] faultAddr = '0;
  logic taken, newSlot;
  logic [31:0] newPc, newVbr, newSr, savedPc, savedSr, savedR15, expEvt, intEvt, tra, tea;

  int nTests = 0, nFail = 0;

  always #2 clk = ~clk;

  excEntry i_excEntry (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    rstReq = '0; mhitReq = '0; faultReq = '0; nmiReq = 1'b0; irqLevel = '0;
    inDelaySlot = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] expCode(int i);
    case (i)
      0, 9: return 32'h040;  1, 14: return 32'h0E0;  2, 12: return 32'h0A0;
      3: return 32'h180;  4: return 32'h1A0;  5: return 32'h800;  6: return 32'h820;
      7: return 32'h160;  8, 17: return 32'h1E0;  10: return 32'h060;
      11: return 32'h080; 13: return 32'h0C0; 15: return 32'h100; 16: return 32'h120;
      default: return 32'hFFFF;
    endcase
  endfunction

  function automatic logic [31:0] expOfs(int i);
    return (i == 0 || i == 9 || i == 10) ? 32'h400 : 32'h100;
  endfunction

  function automatic logic [31:0] expSave(int i, logic [31:0] pc);
    if (i == 7 || i == 17) return pc + 2;
    if (i == 4 || i == 6)  return pc - 2;
    return pc;
  endfunction

  task automatic testResetState();
    chk("R1 taken", {31'd0, taken}, 0);
    chk("R1 newPc", newPc, 0);
    chk("R1 expEvt", expEvt, 0);
    chk("R1 tea", tea, 0);
    chk("R1 newSlot", {31'd0, newSlot}, 0);
  endtask

  task automatic testGeneral();
    for (int i = 0; i < NUM_FAULT; i++) begin
      clearIn();
      faultReq[i] = 1'b1;
      curPc = 32'h8C00_1000 + 32'(i) * 16;
      faultAddr = 32'h1234_0000 + 32'(i);
      trapImm = 8'h21;
      tick();
      chk($sformatf("R4/R5 code bit %0d", i), expEvt, expCode(i));
      chk($sformatf("R4/R5 vector bit %0d", i), newPc, curVbr + expOfs(i));
      chk($sformatf("R7 savedPc bit %0d", i), savedPc, expSave(i, curPc));
      chk($sformatf("R6 savedSr bit %0d", i), savedSr, curSr);
      chk($sformatf("R6 savedR15 bit %0d", i), savedR15, curR15);
      chk($sformatf("R6 newSr bit %0d", i), newSr, 32'h7000_8050);
      chk($sformatf("R6 newVbr bit %0d", i), newVbr, curVbr);
      chk($sformatf("R13 taken bit %0d", i), {31'd0, taken}, 1);
      if (i == 0 || i == 1 || i == 2 || (i >= 9 && i <= 15))
        chk($sformatf("R12 tea bit %0d", i), tea, faultAddr);
    end
    clearIn();
    tick();
    chk("R13 taken drops", {31'd0, taken}, 0);
  endtask

  task automatic testTrap();
    clearIn();
    faultReq[7] = 1'b1; trapImm = 8'hC3; faultAddr = 32'hDEAD_0000;
    tick();
    chk("R8 tra", tra, 32'h0000_030C);
    chk("R12 tea held", tea, 32'h1234_000F);
    clearIn(); faultReq[3] = 1'b1; trapImm = 8'h11;
    tick();
    chk("R8 tra unchanged", tra, 32'h0000_030C);
  endtask

  task automatic testResets();
    logic [31:0] keepPc;
    keepPc = savedPc;
    clearIn(); rstReq = 2'b11; curSr = 32'h0000_8000;
    tick();
    chk("R2 power-on code", expEvt, 32'h000);
    chk("R2 newPc", newPc, 32'hA000_0000);
    chk("R2 newVbr", newVbr, 0);
    chk("R2 newSr", newSr, 32'h7000_00F0);
    chk("R2 savedPc untouched", savedPc, keepPc);
    clearIn(); rstReq = 2'b10; faultReq[3] = 1'b1;
    tick();
    chk("R2 manual code", expEvt, 32'h020);
    clearIn(); mhitReq = 2'b10; faultReq[0] = 1'b1; faultAddr = 32'hCAFE_0040;
    tick();
    chk("R3 multihit code", expEvt, 32'h140);
    chk("R3 newPc", newPc, 32'hA000_0000);
    chk("R3 tea", tea, 32'hCAFE_0040);
    chk("R3 savedPc untouched", savedPc, keepPc);
    curSr = 32'h0000_8050;
  endtask

  task automatic testInterrupts();
    logic [31:0] keepExp, keepPc;
    clearIn(); irqLevel = 4'd6;
    tick();
    chk("R9 level code", intEvt, 32'h320);
    chk("R9 vector", newPc, curVbr + 32'h600);
    keepExp = expEvt; keepPc = newPc;
    clearIn(); irqLevel = 4'd5;
    tick();
    chk("R10 level==mask", {31'd0, taken}, 0);
    chk("R10 newPc held", newPc, keepPc);
    clearIn(); irqLevel = 4'd15; curSr = 32'h1000_0050;
    tick();
    chk("R10 BL blocks", {31'd0, taken}, 0);
    clearIn(); nmiReq = 1'b1;
    tick();
    chk("R10 NMI with BL", {31'd0, taken}, 1);
    chk("R9 NMI code", intEvt, 32'h1C0);
    chk("R9 expEvt held", expEvt, keepExp);
    curSr = 32'h0000_8000;
    clearIn(); irqLevel = 4'd1;
    tick();
    chk("R9 level 1 code", intEvt, 32'h3C0);
    curSr = 32'h0000_8050;
  endtask

  task automatic testPriority();
    clearIn(); faultReq[14] = 1'b1; faultReq[3] = 1'b1;
    tick();
    chk("R11 lowest bit wins", expEvt, 32'h180);
    clearIn(); faultReq[16] = 1'b1; nmiReq = 1'b1; irqLevel = 4'd15;
    tick();
    chk("R11 fault over NMI", expEvt, 32'h120);
    chk("R11 intEvt held", intEvt, 32'h3C0);
    clearIn(); nmiReq = 1'b1; irqLevel = 4'd15;
    tick();
    chk("R11 NMI over level", intEvt, 32'h1C0);
  endtask

  task automatic testSlot();
    clearIn(); inDelaySlot = 1'b1;
    tick();
    chk("R13 slot follows", {31'd0, newSlot}, 1);
    chk("R13 idle no taken", {31'd0, taken}, 0);
    faultReq[5] = 1'b1;
    tick();
    chk("R13 slot cleared", {31'd0, newSlot}, 0);
    clearIn();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testResetState();
    rstN = 1'b1;
    tick();
    testGeneral();
    testTrap();
    testResets();
    testInterrupts();
    testPriority();
    testSlot();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule